// File: doc/BRIEF.md
# Shared Recirculating-Buffer Wavelength Allocator

This controller does the bookkeeping for a set of recirculating buffer loops that hold parked packets. Each loop can carry one packet per wavelength. In every slot (one clock cycle) any input port may ask to park a packet. The controller then grants that port a free wavelength in the loop wired to it, or drops the packet when that loop has no free wavelength left. For every stored packet it records the loop and the wavelength, filed under the packet's destination output.

When an output is reported free, the controller releases the oldest packet waiting for that output. It names the loop and the wavelength to tune for readout, and it marks that wavelength free again from the following slot on. The loops are filled and emptied independently of one another. Packets for the same destination always leave in the order they were parked.

Top module: `wdm_loop_alloc`

## Requirements
- R1: After reset every wavelength is free and every destination queue is empty, so no read is issued even when all outputs are reported free.
- R2: Input port i is served by loop i/D, where D = P/M. Within a loop, the requesting ports of one slot are handled in ascending port order. Each of them takes the lowest-numbered wavelength that is free at the start of the slot and not yet taken by a lower port. The index is reported on `st_wl[i*WLW +: WLW]`.
- R3: A request that finds no free wavelength in its loop is dropped: `st_drop[i]` is high and `st_gnt[i]` is low. A port with no request gets neither.
- R4: Loops are independent. A full loop never causes a drop on a port of another loop. The loop number of a released packet, reported on `rd_mod`, is the loop of the port that parked it.
- R5: A granted wavelength stays occupied until its packet is read. A read frees the wavelength for allocation from the next slot onward, not in the slot of the read.
- R6: Output j gets a read (`rd_vld[j]` high) exactly when `out_free[j]` is high and at least one packet for j is stored. At most one packet per output is read per slot.
- R7: Packets for the same destination are read in parking order. Packets parked in the same slot are ordered by ascending input port. The read reports the stored loop on `rd_mod[j*MW +: MW]` and the wavelength on `rd_wl[j*WLW +: WLW]`.
- R8: A packet parked in a slot can be read no earlier than the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req | input | P | Per input port: packet to park this slot |
| st_dst | input | P*DSTW | Per input port: destination output, field i at bits i*DSTW |
| st_gnt | output | P | Per input port: wavelength granted |
| st_drop | output | P | Per input port: request dropped, loop full |
| st_wl | output | P*WLW | Per input port: granted wavelength index |
| out_free | input | P | Per output: contention cleared, may receive a parked packet |
| rd_vld | output | P | Per output: a parked packet is released this slot |
| rd_mod | output | P*MW | Per output: loop holding the released packet |
| rd_wl | output | P*WLW | Per output: wavelength of the released packet |

## Verification
The hardest case to reach is a loop that is completely full while, in the same slot, one of its packets is being read and a new request arrives. The new request must still be dropped, and it must win that wavelength one slot later. A directed sequence fills one loop with output release held off, then raises one output together with a request and checks both slots. Beyond that, a long pseudo-random run alternates phases of heavy parking with few releases, and phases with the opposite mix. This drives the loops through full, partly full and empty states and produces same-slot pushes to one destination. Every output is compared each slot against an arithmetic model of occupancy and per-destination queues.

// File: rtl/wdm_loop_alloc.sv
module wdm_loop_alloc #(
  parameter int P = 8,
  parameter int M = 2,
  parameter int W = 4,
  localparam int D    = P / M,
  localparam int DSTW = (P > 1) ? $clog2(P) : 1,
  localparam int WLW  = (W > 1) ? $clog2(W) : 1,
  localparam int MW   = (M > 1) ? $clog2(M) : 1,
  localparam int TAGW = MW + WLW,
  localparam int Q    = M * W,
  localparam int PW   = (Q > 1) ? $clog2(Q) : 1,
  localparam int CW   = $clog2(Q + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P-1:0]      st_req,
  input  logic [P*DSTW-1:0] st_dst,
  output logic [P-1:0]      st_gnt,
  output logic [P-1:0]      st_drop,
  output logic [P*WLW-1:0]  st_wl,
  input  logic [P-1:0]      out_free,
  output logic [P-1:0]      rd_vld,
  output logic [P*MW-1:0]   rd_mod,
  output logic [P*WLW-1:0]  rd_wl
);

  logic [M*W-1:0]  occ, occ_set, occ_clr;
  logic [TAGW-1:0] q [P][Q];
  logic [PW-1:0]   head [P];
  logic [CW-1:0]   cnt [P];
  logic [WLW-1:0]  wl_a [P];
  logic [CW-1:0]   off [P];
  logic [CW-1:0]   npush [P];
  logic [PW-1:0]   wr_pos [P];
  logic [DSTW-1:0] dst [P];
  logic [TAGW-1:0] rd_tag [P];
  int              rd_idx [P];

  function automatic logic [PW-1:0] wrap(input int a);
    return PW'((a >= Q) ? a - Q : a);
  endfunction

  // lowest free wavelength per requester, ports of a loop in ascending order
  always_comb begin
    st_gnt  = '0;
    occ_set = '0;
    for (int i = 0; i < P; i++) wl_a[i] = '0;
    for (int m = 0; m < M; m++) begin
      for (int k = 0; k < D; k++) begin
        if (st_req[m*D+k]) begin
          for (int b = W - 1; b >= 0; b--) begin
            if (!occ[m*W+b] && !occ_set[m*W+b]) begin
              st_gnt[m*D+k] = 1'b1;
              wl_a[m*D+k]   = WLW'(b);
            end
          end
          if (st_gnt[m*D+k]) occ_set[m*W+int'(wl_a[m*D+k])] = 1'b1;
        end
      end
    end
  end

  assign st_drop = st_req & ~st_gnt;

  // queue bookkeeping: offsets of same-slot pushes, push counts, write slots
  always_comb begin
    for (int i = 0; i < P; i++) begin
      dst[i] = st_dst[i*DSTW +: DSTW];
      off[i] = '0;
      npush[i] = '0;
    end
    for (int i = 0; i < P; i++)
      for (int j = 0; j < i; j++)
        if (st_gnt[j] && dst[j] == dst[i]) off[i] = off[i] + 1'b1;
    for (int i = 0; i < P; i++)
      if (st_gnt[i] && int'(dst[i]) < P) npush[dst[i]] = npush[dst[i]] + 1'b1;
    for (int i = 0; i < P; i++)
      wr_pos[i] = (int'(dst[i]) < P) ?
                  wrap(int'(head[dst[i]]) + int'(cnt[dst[i]]) + int'(off[i])) : '0;
  end

  genvar g;
  generate
    for (g = 0; g < P; g++) begin : g_port
      assign st_wl[g*WLW +: WLW] = wl_a[g];
      assign rd_tag[g]           = q[g][head[g]];
      assign rd_vld[g]           = out_free[g] && (cnt[g] != '0);
      assign rd_mod[g*MW +: MW]  = rd_tag[g][TAGW-1:WLW];
      assign rd_wl[g*WLW +: WLW] = rd_tag[g][WLW-1:0];
      assign rd_idx[g]           = int'(rd_tag[g][TAGW-1:WLW]) * W + int'(rd_tag[g][WLW-1:0]);
    end
  endgenerate

  always_comb begin
    occ_clr = '0;
    for (int j = 0; j < P; j++)
      if (rd_vld[j] && rd_idx[j] < M*W) occ_clr[rd_idx[j]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int j = 0; j < P; j++) begin
        head[j] <= '0;
        cnt[j]  <= '0;
      end
    end else begin
      occ <= (occ & ~occ_clr) | occ_set;
      for (int j = 0; j < P; j++) begin
        cnt[j]  <= cnt[j] + npush[j] - (rd_vld[j] ? CW'(1) : CW'(0));
        head[j] <= rd_vld[j] ? wrap(int'(head[j]) + 1) : head[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < P; i++)
      if (rst_n && st_gnt[i] && int'(dst[i]) < P)
        q[dst[i]][wr_pos[i]] <= {MW'(i / D), wl_a[i]};
  end

  int tot_q;
  always_comb begin
    tot_q = 0;
    for (int j = 0; j < P; j++) tot_q = tot_q + int'(cnt[j]);
  end

  // R2
  grant_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_set & occ) == '0);

  // R5
  store_matches_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == tot_q);

  generate
    for (g = 0; g < P; g++) begin : g_chk
      // R3
      drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_drop[g] |-> &(occ[(g/D)*W +: W] | occ_set[(g/D)*W +: W]));
      // R5
      read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld[g] && rd_idx[g] < M*W) |=> !occ[$past(rd_idx[g])]);
      for (genvar h = g + 1; h < P; h++) begin : g_pair
        if ((g / D) == (h / D)) begin : g_same
          // R2
          distinct_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_gnt[g] && st_gnt[h]) |-> (wl_a[g] != wl_a[h]));
        end
      end
    end
  endgenerate

endmodule

// File: tb/tb_wdm_loop_alloc.sv
module tb_wdm_loop_alloc;
  localparam int P = 4, M = 2, W = 2, D = P / M;
  localparam int DSTW = 2, WLW = 1, MW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [P-1:0] st_req = '0, out_free = '0;
  logic [P*DSTW-1:0] st_dst = '0;
  logic [P-1:0] st_gnt, st_drop, rd_vld;
  logic [P*WLW-1:0] st_wl, rd_wl;
  logic [P*MW-1:0] rd_mod;

  int tests = 0, fails = 0;
  bit mocc [M*W];
  int mq [P][64];
  int mhead [P];
  int mcnt [P];
  logic [31:0] lfsr = 32'h1D2C3B4A;

  always #10 clk = ~clk;

  wdm_loop_alloc #(.P(P), .M(M), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_dst(st_dst),
    .st_gnt(st_gnt), .st_drop(st_drop), .st_wl(st_wl),
    .out_free(out_free), .rd_vld(rd_vld), .rd_mod(rd_mod), .rd_wl(rd_wl));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic step(input logic [P-1:0] rq, input logic [P*DSTW-1:0] ds,
                      input logic [P-1:0] fr);
    bit taken [M*W];
    int gw [P];
    bit gg [P];
    @(negedge clk);
    st_req = rq; st_dst = ds; out_free = fr;
    #9;
    for (int k = 0; k < M*W; k++) taken[k] = mocc[k];
    for (int p = 0; p < P; p++) begin
      gg[p] = 1'b0; gw[p] = 0;
      if (rq[p]) begin
        for (int b = 0; b < W; b++)
          if (!gg[p] && !taken[(p/D)*W+b]) begin gg[p] = 1'b1; gw[p] = b; end
        if (gg[p]) taken[(p/D)*W+gw[p]] = 1'b1;
      end
      chk("R2 R4 grant", int'(st_gnt[p]), int'(gg[p]));
      chk("R3 drop", int'(st_drop[p]), int'(rq[p] && !gg[p]));
      if (gg[p]) chk("R2 wavelength", int'(st_wl[p*WLW +: WLW]), gw[p]);
    end
    for (int j = 0; j < P; j++) begin
      bit er;
      er = fr[j] && mcnt[j] > 0;
      chk("R6 read valid", int'(rd_vld[j]), int'(er));
      if (er) begin
        int t;
        t = mq[j][mhead[j]];
        chk("R4 R7 read loop", int'(rd_mod[j*MW +: MW]), t / W);
        chk("R7 read wavelength", int'(rd_wl[j*WLW +: WLW]), t % W);
        mocc[t] = 1'b0;
        mhead[j] = (mhead[j] + 1) % 64;
        mcnt[j]--;
      end
    end
    for (int p = 0; p < P; p++)
      if (gg[p]) begin
        int d;
        d = int'(ds[p*DSTW +: DSTW]);
        mocc[(p/D)*W+gw[p]] = 1'b1;
        mq[d][(mhead[d] + mcnt[d]) % 64] = (p/D)*W + gw[p];
        mcnt[d]++;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < M*W; k++) mocc[k] = 1'b0;
    for (int j = 0; j < P; j++) begin mhead[j] = 0; mcnt[j] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty after reset, nothing released
    out_free = '1; #9;
    chk("R1 no read after reset", int'(rd_vld), 0);
    chk("R1 no grant without request", int'(st_gnt), 0);

    // R8: park for output 3 with output 3 free; no same-slot release
    step(4'b0001, {2'd0, 2'd0, 2'd0, 2'd3}, 4'b1000);
    chk("R8 same-slot read blocked", int'(rd_vld[3]), 0);
    step(4'b0000, '0, 4'b1000);
    chk("R8 read next slot", int'(rd_vld[3]), 1);

    // R5: fill loop 0, read one wavelength and request in the same slot
    step(4'b0011, {2'd0, 2'd0, 2'd1, 2'd0}, 4'b0000);
    step(4'b0001, {2'd0, 2'd0, 2'd0, 2'd2}, 4'b0001);
    chk("R5 freed wavelength not reused same slot", int'(st_drop[0]), 1);
    step(4'b0001, {2'd0, 2'd0, 2'd0, 2'd2}, 4'b0000);
    chk("R5 freed wavelength reused next slot", int'(st_gnt[0]), 1);
    // R4: loop 0 full, loop 1 still grants
    step(4'b0101, {2'd0, 2'd2, 2'd0, 2'd2}, 4'b0000);
    chk("R4 other loop unaffected", int'(st_gnt[2]), 1);
    chk("R3 full loop drops", int'(st_drop[0]), 1);
    // R7: same-slot pushes to one destination ordered by port
    step(4'b0000, '0, 4'b1111);
    step(4'b0000, '0, 4'b1111);
    step(4'b0000, '0, 4'b1111);
    step(4'b1111, {2'd1, 2'd1, 2'd1, 2'd1}, 4'b0000);
    step(4'b0000, '0, 4'b0010);
    chk("R7 first of slot is port 0 loop", int'(rd_mod[MW +: MW]), 0);

    for (int c = 0; c < 6000; c++) begin
      logic [P-1:0] rq, fr;
      nxt(); rq = lfsr[3:0];
      nxt(); fr = lfsr[3:0];
      case ((c / 400) % 3)
        0: fr = fr & lfsr[7:4];
        1: rq = rq & lfsr[11:8];
        default: ;
      endcase
      nxt();
      step(rq, lfsr[7:0], fr);
    end
    for (int c = 0; c < 20; c++) step('0, '0, '1);
    for (int j = 0; j < P; j++) chk("R6 all queues drained", mcnt[j], 0);
    chk("R6 no read when empty", int'(rd_vld), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule